// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Controller

This controller collects interrupt requests from four internal sources and takes part in an external priority chain of devices. An upstream enable tells it that no higher device is asking for service. It passes a downstream enable to lower devices only while none of its own sources is being serviced and it is not itself claiming an acknowledge. Each source is qualified by an arm bit and ordered by a fixed priority. Index 0 is receive status and has the highest priority, then receive data (1), then transmit status (2), then transmit data (3).

When the host acknowledges, the highest-priority source that is armed, pending and not masked is moved into service. The controller then presents a vector equal to a base value plus the source index. An in-service source masks itself and every source of lower priority until software clears its bit. Software clears the bit either with a 2-bit command on a chosen set of in-service bits, or with a strobe that clears only the highest-priority in-service bit.

Top module: `isr_chain_ctl`

## Requirements
- R1: After reset, all in-service bits are 0, `irq_n_o` is 1 and `vec_vld_o` is 0.
- R2: `irq_n_o` is 0 only when `ie_i` is 1 and some source i is both pending and armed, with no in-service bit set at any index 0..i. It is 1 in every other case.
- R3: A source whose arm bit is 0 never causes `irq_n_o` to go low and is never placed into service.
- R4: Priority is fixed, with index 0 highest. While `iack_i` is high in a cycle where `irq_n_o` is low, the next clock edge sets the in-service bit of the lowest-index requesting source. On that edge `vec_vld_o` goes high for one cycle and `vec_o` becomes VEC_BASE plus that index.
- R5: A set in-service bit at index k masks requests from indices k and above. Requests from indices below k still assert `irq_n_o`.
- R6: `ie_o` equals `ie_i` when no in-service bit is set and the controller is not claiming an acknowledge (`iack_i` high while `irq_n_o` low). In all other cases `ie_o` is 0.
- R7: An acknowledge while `ie_i` is 0 changes no in-service bit and gives no `vec_vld_o` pulse.
- R8: With `cmd_we_i` high, `cmd_code_i` = 2'b10 clears the in-service bits selected by `cmd_sel_i` at the next edge, and 2'b11 sets them. Codes 2'b00 and 2'b01 leave the in-service bits unchanged.
- R9: A `rst_hi_i` strobe clears only the lowest-index in-service bit that is set, at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_SRC | Pending level per source (index 0 highest priority) |
| arm_i | input | N_SRC | Arm bit per source |
| ie_i | input | 1 | Chain enable from the higher-priority neighbour |
| ie_o | output | 1 | Chain enable to the lower-priority neighbour |
| irq_n_o | output | 1 | Active-low interrupt request |
| iack_i | input | 1 | Interrupt acknowledge, one cycle |
| cmd_we_i | input | 1 | In-service command strobe |
| cmd_code_i | input | 2 | In-service command code (0x none, 10 clear, 11 set) |
| cmd_sel_i | input | N_SRC | In-service bits the command acts on |
| rst_hi_i | input | 1 | Clear the highest-priority in-service bit |
| ius_o | output | N_SRC | Current in-service bits |
| vec_o | output | VEC_W | Vector of the last acknowledged source |
| vec_vld_o | output | 1 | One-cycle pulse when a new vector is loaded |

## Verification
Several properties are checked on every cycle. A granted acknowledge adds exactly one in-service bit and pulses the vector strobe. A vector pulse only ever follows an enabled acknowledge. Any in-service bit forces the downstream enable low. The no-operation codes leave the in-service bits untouched, and the reset-highest strobe removes exactly one bit. Only the bench scenarios can show that the correct source wins and that the right vector value comes out. They also show the masking of equal and lower priorities while higher ones still get through, and that unarmed or upstream-disabled requests go nowhere.

// File: rtl/isr_chain_ctl.sv
module isr_chain_ctl #(
  parameter int N_SRC    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] arm_i,
  input  logic             ie_i,
  output logic             ie_o,
  output logic             irq_n_o,
  input  logic             iack_i,
  input  logic             cmd_we_i,
  input  logic [1:0]       cmd_code_i,
  input  logic [N_SRC-1:0] cmd_sel_i,
  input  logic             rst_hi_i,
  output logic [N_SRC-1:0] ius_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] ius, mask, cand, win_oh, hi_ius, ius_nxt;
  logic [IDX_W-1:0] win_idx;
  logic             any_req, grant;

  always_comb begin
    mask[0] = ius[0];
    for (int i = 1; i < N_SRC; i++) mask[i] = mask[i-1] | ius[i];
  end

  assign cand    = pend_i & arm_i & ~mask;
  assign win_oh  = cand & (~cand + 1'b1);
  assign hi_ius  = ius & (~ius + 1'b1);
  assign any_req = |cand;
  assign grant   = iack_i & ie_i & any_req;

  always_comb begin
    win_idx = '0;
    for (int i = N_SRC-1; i >= 0; i--)
      if (cand[i]) win_idx = IDX_W'(i);
  end

  always_comb begin
    ius_nxt = ius;
    if (rst_hi_i) ius_nxt = ius_nxt & ~hi_ius;
    if (cmd_we_i && cmd_code_i == 2'b10) ius_nxt = ius_nxt & ~cmd_sel_i;
    if (cmd_we_i && cmd_code_i == 2'b11) ius_nxt = ius_nxt | cmd_sel_i;
    if (grant) ius_nxt = ius_nxt | win_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ius       <= '0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      ius       <= ius_nxt;
      vec_vld_o <= grant;
      if (grant) vec_o <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end
  end

  assign irq_n_o = ~(ie_i & any_req);
  assign ie_o    = ie_i & ~(|ius) & ~(iack_i & any_req);
  assign ius_o   = ius;

  p_ack_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && !irq_n_o && !cmd_we_i && !rst_hi_i)
    |=> ($countones(ius_o) == $countones($past(ius_o)) + 1) && vec_vld_o);

  p_vec_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> $past(iack_i && ie_i));

  p_ius_blocks_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_o) |-> !ie_o);

  p_noop_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && !cmd_code_i[1] && !rst_hi_i && !iack_i) |=> $stable(ius_o));

  p_rst_hi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hi_i && (|ius_o) && !cmd_we_i && !iack_i)
    |=> $countones(ius_o) == $countones($past(ius_o)) - 1);

  p_irq_needs_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |-> irq_n_o);
endmodule

// File: tb/isr_chain_ctl_tb.sv
module isr_chain_ctl_tb;
  localparam int PERIOD = 10;
  localparam int N = 4;
  localparam int BASE = 64;
  localparam int NV = 12;
  // {ius, ie, pend, arm, exp_irq_n, exp_ie_o}
  localparam logic [14:0] VECS [NV] = '{
    {4'b0000, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b1},
    {4'b0000, 1'b1, 4'b0001, 4'b1111, 1'b0, 1'b1},
    {4'b0000, 1'b0, 4'b0001, 4'b1111, 1'b1, 1'b0},
    {4'b0000, 1'b1, 4'b1000, 4'b0111, 1'b1, 1'b1},
    {4'b0000, 1'b1, 4'b1000, 4'b1000, 1'b0, 1'b1},
    {4'b0001, 1'b1, 4'b0010, 4'b1111, 1'b1, 1'b0},
    {4'b0100, 1'b1, 4'b0001, 4'b1111, 1'b0, 1'b0},
    {4'b0100, 1'b1, 4'b0100, 4'b1111, 1'b1, 1'b0},
    {4'b0100, 1'b1, 4'b1000, 4'b1111, 1'b1, 1'b0},
    {4'b1000, 1'b1, 4'b0111, 4'b1111, 1'b0, 1'b0},
    {4'b0000, 1'b1, 4'b1111, 4'b0000, 1'b1, 1'b1},
    {4'b0010, 1'b0, 4'b0001, 4'b1111, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend_i = 0, arm_i = 0, cmd_sel_i = 0, ius_o;
  logic ie_i = 0, ie_o, irq_n_o, iack_i = 0, cmd_we_i = 0, rst_hi_i = 0, vec_vld_o;
  logic [1:0] cmd_code_i = 0;
  logic [7:0] vec_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  isr_chain_ctl #(.N_SRC(N), .VEC_W(8), .VEC_BASE(BASE)) u_dut (
    .clk, .rst_n, .pend_i, .arm_i, .ie_i, .ie_o, .irq_n_o, .iack_i,
    .cmd_we_i, .cmd_code_i, .cmd_sel_i, .rst_hi_i, .ius_o, .vec_o, .vec_vld_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] code, logic [N-1:0] sel);
    cmd_we_i = 1; cmd_code_i = code; cmd_sel_i = sel;
    @(negedge clk);
    cmd_we_i = 0; cmd_code_i = 0; cmd_sel_i = 0;
  endtask

  task automatic load_ius(logic [N-1:0] v);
    cmd(2'b10, '1);
    cmd(2'b11, v);
  endtask

  task automatic ack();
    iack_i = 1;
    @(negedge clk);
    iack_i = 0;
  endtask

  task automatic strobe_hi();
    rst_hi_i = 1;
    @(negedge clk);
    rst_hi_i = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    ie_i = 1;
    #1;
    check("R1 ius", ius_o, 0);
    check("R1 irq_n", irq_n_o, 1);
    check("R1 vec_vld", vec_vld_o, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VECS[k]) begin
      load_ius(VECS[k][14:11]);
      ie_i = VECS[k][10]; pend_i = VECS[k][9:6]; arm_i = VECS[k][5:2];
      #1;
      check($sformatf("R2/R3/R5 irq_n vec%0d", k), irq_n_o, VECS[k][1]);
      check($sformatf("R6 ie_o vec%0d", k), ie_o, VECS[k][0]);
      @(negedge clk);
    end

    // R4 priority and vector
    ie_i = 1; arm_i = 4'b1111; pend_i = 4'b1110;
    load_ius(0);
    iack_i = 1; #1;
    check("R6 ie_o low while claiming ack", ie_o, 0);
    @(negedge clk); iack_i = 0;
    check("R4 ius after ack", ius_o, 4'b0010);
    check("R4 vec_vld", vec_vld_o, 1);
    check("R4 vec", vec_o, BASE + 1);
    @(negedge clk);
    check("R4 vec_vld one cycle", vec_vld_o, 0);
    check("R5 lower masked", irq_n_o, 1);
    pend_i = 4'b1111; #1;
    check("R5 higher passes", irq_n_o, 0);
    ack();
    check("R4 nested ius", ius_o, 4'b0011);
    check("R4 nested vec", vec_o, BASE + 0);

    // R9 reset highest
    pend_i = 0;
    strobe_hi();
    check("R9 first clear", ius_o, 4'b0010);
    load_ius(4'b1010);
    strobe_hi();
    check("R9 only highest", ius_o, 4'b1000);

    // R8 command codes
    cmd(2'b01, 4'b1111);
    check("R8 code 01 no-op", ius_o, 4'b1000);
    cmd(2'b00, 4'b1111);
    check("R8 code 00 no-op", ius_o, 4'b1000);
    cmd(2'b11, 4'b0101);
    check("R8 set", ius_o, 4'b1101);
    cmd(2'b10, 4'b1001);
    check("R8 clear", ius_o, 4'b0100);

    // R7 ack with chain disabled
    load_ius(0);
    ie_i = 0; pend_i = 4'b0001; arm_i = 4'b1111;
    ack();
    check("R7 ius unchanged", ius_o, 0);
    check("R7 no vec pulse", vec_vld_o, 0);

    // R3 unarmed source not serviced
    ie_i = 1; pend_i = 4'b0001; arm_i = 4'b1110;
    ack();
    check("R3 unarmed not serviced", ius_o, 0);
    check("R3 no vec pulse", vec_vld_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule